// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block protects a twisted-pair transmitter from a transmit stream that never stops. It counts how many consecutive clock cycles the transmit-active input has been high. If the run goes past a set limit, the block enters the jabber condition. In that condition it cuts the transmit data path, forces the transmit-active indication off and asserts collision. It also sets a sticky jabber status bit, which drives an interrupt request unless a mask input blocks it. Link-test pulses pass through at all times, whether or not the block is jabbing.

The jabber condition clears only after the transmit stream has been quiet for a full unjab interval. If transmission resumes during that interval, the quiet count is discarded and starts again from zero the next time the stream stops. Both intervals are parameters counted in clock cycles. Real hardware uses values for tens and hundreds of milliseconds, and simulation can use short ones.

Top module: `tx_jabber_guard`

## Requirements
- R1: After reset the block is not jabbing. Collision, the jabber status bit and the interrupt request are all 0.
- R2: While not jabbing, the transmit-active indication equals the transmit-active input and the data output equals the data input, in the same cycle.
- R3: Jabber is entered at the clock edge where the transmit-active input is high for the (JAB_LIMIT+1)-th consecutive cycle. A run of exactly JAB_LIMIT high cycles does not trigger it, and any low cycle restarts the count.
- R4: While jabbing, the data output and the transmit-active indication are 0 and the collision output is 1.
- R5: The link-pulse output equals the link-pulse input in every cycle, including while jabbing.
- R6: The jabber status bit is set at the same edge that jabber is entered. It stays 1 until a cycle with the clear strobe high. If set and clear occur in the same cycle, set wins.
- R7: The interrupt request equals the status bit AND NOT the mask input, where mask = 1 blocks the request.
- R8: Jabber is released at the UNJAB_CYCLES-th consecutive clock edge at which the transmit-active input is low. No release happens while the transmit-active input is high.
- R9: If the transmit-active input goes high during the unjab interval, the quiet count is discarded. Release then needs UNJAB_CYCLES new consecutive low edges.
- R10: After release, a new jabber trigger needs a fresh run of JAB_LIMIT+1 consecutive high cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_active_i | input | 1 | Transmit stream active |
| tx_data_i | input | 1 | Transmit data bit toward the line |
| link_pulse_i | input | 1 | Link-test pulse request |
| irq_mask_i | input | 1 | 1 blocks the jabber interrupt |
| irq_clr_i | input | 1 | Read-clear strobe for the status bit |
| tx_data_o | output | 1 | Gated transmit data |
| tx_en_o | output | 1 | Transmit-active indication |
| link_pulse_o | output | 1 | Link-test pulse output |
| col_o | output | 1 | Collision indication |
| jab_flag_o | output | 1 | Sticky jabber status bit |
| irq_o | output | 1 | Jabber interrupt request |

## Verification
The embedded assertions check these rules on every cycle:
- Jabber is entered only after the run counter has reached its limit with transmit still active.
- Jabber is released only after a full quiet count with transmit low.
- The block never leaves jabber while transmit is active.
- The status bit rises with jabber entry and falls only after a clear strobe.

Only the bench scenarios can show the exact boundary: that JAB_LIMIT high cycles do not trigger and JAB_LIMIT+1 do. The same holds for the discarded quiet count after a resumed stream, the fresh count after release, and the mask and clear interaction with the interrupt output.

// File: rtl/txj_pkg.sv
package txj_pkg;

   typedef enum logic [1:0] {
      TXJ_NORMAL    = 2'd0,
      TXJ_JAB_ON    = 2'd1,
      TXJ_JAB_QUIET = 2'd2
   } txj_state_e;

   function automatic int txj_cnt_width(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/txj_run_counter.sv
module txj_run_counter
   import txj_pkg::*;
#(
   parameter int LIMIT = 16,
   parameter int W     = txj_cnt_width(LIMIT)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         at_limit
);

   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   if (LIMIT < 0) begin : g_bad_limit
      $error("txj_run_counter: LIMIT must not be negative");
   end

   assign at_limit = (cnt == LIM_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (en && !at_limit) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM_V);

endmodule

// File: rtl/txj_ctrl.sv
module txj_ctrl
   import txj_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_active,
   input  logic       run_at_limit,
   input  logic       quiet_at_limit,
   output txj_state_e state,
   output logic       jabbing,
   output logic       enter_jab,
   output logic       run_en,
   output logic       run_clr,
   output logic       quiet_en,
   output logic       quiet_clr
);

   txj_state_e state_nx;

   assign jabbing   = (state != TXJ_NORMAL);
   assign run_en    = (state == TXJ_NORMAL) && tx_active;
   assign run_clr   = !run_en;
   assign quiet_en  = jabbing && !tx_active;
   assign quiet_clr = !quiet_en;
   assign enter_jab = (state == TXJ_NORMAL) && tx_active && run_at_limit;

   always_comb begin
      state_nx = state;
      unique case (state)
         TXJ_NORMAL: begin
            if (enter_jab) state_nx = TXJ_JAB_ON;
         end
         TXJ_JAB_ON: begin
            if (!tx_active) state_nx = quiet_at_limit ? TXJ_NORMAL : TXJ_JAB_QUIET;
         end
         TXJ_JAB_QUIET: begin
            if (tx_active)           state_nx = TXJ_JAB_ON;
            else if (quiet_at_limit) state_nx = TXJ_NORMAL;
         end
         default: state_nx = TXJ_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= TXJ_NORMAL;
      else        state <= state_nx;
   end

   // R9
   hold_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (jabbing && tx_active) |=> jabbing);

endmodule

// File: rtl/txj_irq.sv
module txj_irq #(
   parameter bit REG_IRQ = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic mask,
   output logic flag,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

   if (REG_IRQ) begin : g_reg_irq
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag && !mask;
      end
      assign irq = irq_q;
   end else begin : g_comb_irq
      assign irq = flag && !mask;
   end

   // R6
   flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(clr));

endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
   import txj_pkg::*;
#(
   parameter int JAB_LIMIT    = 1_000_000,
   parameter int UNJAB_CYCLES = 25_000_000,
   parameter bit REG_IRQ      = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tx_active_i,
   input  logic tx_data_i,
   input  logic link_pulse_i,
   input  logic irq_mask_i,
   input  logic irq_clr_i,
   output logic tx_data_o,
   output logic tx_en_o,
   output logic link_pulse_o,
   output logic col_o,
   output logic jab_flag_o,
   output logic irq_o
);

   localparam int QUIET_LIMIT = UNJAB_CYCLES - 1;
   localparam int RUN_W       = txj_cnt_width(JAB_LIMIT);
   localparam int QUIET_W     = txj_cnt_width(QUIET_LIMIT);

   if (JAB_LIMIT < 1) begin : g_bad_jab
      $error("tx_jabber_guard: JAB_LIMIT must be at least 1");
   end
   if (UNJAB_CYCLES < 1) begin : g_bad_unjab
      $error("tx_jabber_guard: UNJAB_CYCLES must be at least 1");
   end

   txj_state_e           state;
   logic                 jabbing, enter_jab;
   logic                 run_en, run_clr, quiet_en, quiet_clr;
   logic                 run_at_limit, quiet_at_limit;
   logic [RUN_W-1:0]     run_cnt;
   logic [QUIET_W-1:0]   quiet_cnt;

   txj_run_counter #(.LIMIT(JAB_LIMIT), .W(RUN_W)) i_run_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (run_clr),
      .en       (run_en),
      .cnt      (run_cnt),
      .at_limit (run_at_limit)
   );

   txj_run_counter #(.LIMIT(QUIET_LIMIT), .W(QUIET_W)) i_quiet_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (quiet_clr),
      .en       (quiet_en),
      .cnt      (quiet_cnt),
      .at_limit (quiet_at_limit)
   );

   txj_ctrl i_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .tx_active      (tx_active_i),
      .run_at_limit   (run_at_limit),
      .quiet_at_limit (quiet_at_limit),
      .state          (state),
      .jabbing        (jabbing),
      .enter_jab      (enter_jab),
      .run_en         (run_en),
      .run_clr        (run_clr),
      .quiet_en       (quiet_en),
      .quiet_clr      (quiet_clr)
   );

   txj_irq #(.REG_IRQ(REG_IRQ)) i_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (enter_jab),
      .clr   (irq_clr_i),
      .mask  (irq_mask_i),
      .flag  (jab_flag_o),
      .irq   (irq_o)
   );

   assign tx_data_o    = tx_data_i && !jabbing;
   assign tx_en_o      = tx_active_i && !jabbing;
   assign col_o        = jabbing;
   assign link_pulse_o = link_pulse_i;

   // R3
   jab_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jabbing) |-> ($past(tx_active_i) && ($past(run_cnt) == RUN_W'(JAB_LIMIT))));

   // R8
   jab_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(jabbing) |-> (!$past(tx_active_i) && ($past(quiet_cnt) == QUIET_W'(QUIET_LIMIT))));

   // R6
   flag_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jabbing) |-> jab_flag_o);

endmodule

// File: tb/test_tx_jabber_guard.sv
`timescale 1ns/1ps
module test_tx_jabber_guard;

   localparam int L = 20;
   localparam int U = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_active = 1'b0, tx_data = 1'b0, link_i = 1'b0, mask = 1'b0, clr = 1'b0;
   logic tx_data_o, tx_en_o, link_o, col_o, flag_o, irq_o;

   int checks = 0;
   int fails  = 0;
   int m_run = 0, m_quiet = 0;
   bit m_jab = 1'b0, m_flag = 1'b0;

   always #10 clk = ~clk;

   tx_jabber_guard #(.JAB_LIMIT(L), .UNJAB_CYCLES(U)) i_tx_jabber_guard (
      .clk(clk), .rst_n(rst_n),
      .tx_active_i(tx_active), .tx_data_i(tx_data), .link_pulse_i(link_i),
      .irq_mask_i(mask), .irq_clr_i(clr),
      .tx_data_o(tx_data_o), .tx_en_o(tx_en_o), .link_pulse_o(link_o),
      .col_o(col_o), .jab_flag_o(flag_o), .irq_o(irq_o)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   function automatic bit exp_txen(bit tx, bit jab);
      return tx && !jab;
   endfunction

   task automatic compare();
      chk(m_jab ? "R4" : "R2", "tx_en_o",   tx_en_o,   exp_txen(tx_active, m_jab));
      chk(m_jab ? "R4" : "R2", "tx_data_o", tx_data_o, tx_data && !m_jab);
      chk(m_jab ? "R4" : "R8", "col_o",     col_o,     m_jab);
      chk("R5", "link_pulse_o", link_o, link_i);
      chk("R6", "jab_flag_o",   flag_o, m_flag);
      chk("R7", "irq_o",        irq_o,  m_flag && !mask);
   endtask

   task automatic model_edge();
      bit set_f = 1'b0;
      if (!m_jab) begin
         if (tx_active) begin
            if (m_run == L) begin m_jab = 1'b1; m_quiet = 0; set_f = 1'b1; end
            else m_run++;
         end else m_run = 0;
      end else begin
         m_run = 0;
         if (tx_active) m_quiet = 0;
         else if (m_quiet == U - 1) begin m_jab = 1'b0; m_quiet = 0; end
         else m_quiet++;
      end
      if (set_f) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
   endtask

   task automatic step(bit tx, bit d, bit lp, bit mk, bit cl);
      tx_active = tx; tx_data = d; link_i = lp; mask = mk; clr = cl;
      #1;
      compare();
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic run_active(int n);
      for (int i = 0; i < n; i++) step(1'b1, i[0], 1'b0, 1'b0, 1'b0);
   endtask

   task automatic run_idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, i[1], 1'b0, 1'b0);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "col_o reset",  col_o,  1'b0);
      chk("R1", "flag reset",   flag_o, 1'b0);
      chk("R1", "irq reset",    irq_o,  1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: exactly L active cycles do not trigger
      run_active(L);
      run_idle(1);
      chk("R3", "no jab after L", col_o, 1'b0);
      // R3: L+1 cycles trigger
      run_active(L + 1);
      chk("R3", "jab after L+1", col_o, 1'b1);
      chk("R6", "flag on entry", flag_o, 1'b1);
      // R5 link pulse while jabbing
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R5", "link during jab", link_o, 1'b1);
      run_active(4);
      // R9: restart inside unjab interval
      run_idle(U - 1);
      chk("R8", "still jab at U-1 quiet", col_o, 1'b1);
      run_active(1);
      run_idle(U - 1);
      chk("R9", "quiet count restarted", col_o, 1'b1);
      run_idle(1);
      chk("R8", "released after U quiet", col_o, 1'b0);
      // R7 mask blocks irq
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R7", "masked irq", irq_o, 1'b0);
      // R6 flag held, then cleared
      chk("R6", "flag held", flag_o, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R6", "flag cleared", flag_o, 1'b0);
      // R10 fresh count after release
      run_active(L);
      run_idle(2);
      chk("R10", "no jab on fresh L run", col_o, 1'b0);
      // R6 set wins over clear
      run_active(L);
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R6", "set beats clear", flag_o, 1'b1);
      run_idle(U);
      chk("R8", "released again", col_o, 1'b0);

      // random bursts
      for (int b = 0; b < 80; b++) begin
         int act = $urandom_range(1, L + 12);
         int gap = $urandom_range(1, U + 6);
         for (int i = 0; i < act; i++)
            step(1'b1, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 7) == 0));
         for (int i = 0; i < gap; i++)
            step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 7) == 0));
      end
      summary();
   end

endmodule